// File: doc/BRIEF.md
# PWM Fault Guard

This block is the fault protection front end of a single PWM channel. A channel watches one of several external fault pins, chosen by a binary select field. Every pin is brought into the system clock domain through a two-stage synchronizer. The selected pin then passes through an optional glitch filter, whose duration is a prescaled count set by a 6-bit length field. An edge detector fires on the active transition, which software picks as either rising or falling. A detected edge sets a sticky pending flag.

While the pending flag is set, the channel can be stopped automatically: the timer-enable and PWM-enable bits held here are forced low, and writes to them are refused until software releases the fault. The interrupt request is the pending flag gated by an enable. Software releases the latch with a write-one-to-clear strobe. If that strobe lands in the same cycle as a fresh fault edge, the fault wins.

The block carries no data stream, so it has no valid/ready handshake. All of its pins are plain control and status levels or single-cycle strobes.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset, fault_pend, fault_irq, tmr_en and pwm_en are all 0.
- R2: Only the pin whose index equals pin_sel (binary, 0 to NUM_PINS-1) can set the fault; edges on any other pin are ignored.
- R3: With edge_rising = 1 only a 0-to-1 transition of the selected pin counts as a fault, and with edge_rising = 0 only a 1-to-0 transition counts; the opposite transition is ignored.
- R4: With filt_en = 0, fault_pend rises at the third rising clock edge that samples the new pin level, counting the first such sampling edge as the first.
- R5: With filt_en = 1, the filtered level follows the pin only after the synchronized level has differed from it for 16 x (filt_len + 1) consecutive cycles. fault_pend then rises at the (16 x (filt_len + 1) + 3)-th sampling edge. A pulse shorter than that window is ignored.
- R6: Once set, fault_pend stays 1 until fault_clr is applied.
- R7: fault_clr = 1 with no fault edge in that cycle clears fault_pend at the next clock edge.
- R8: When fault_clr and a new fault edge fall in the same cycle, fault_pend stays 1.
- R9: fault_irq is 1 exactly when fault_pend = 1 and irq_en = 1, with no added cycle.
- R10: With auto_stop_en = 1, a fault clears tmr_en and pwm_en at the same edge that sets fault_pend. While fault_pend remains 1, enable writes are ignored and both bits stay 0.
- R11: en_wr = 1 loads tmr_en from en_wr_tmr and pwm_en from en_wr_pwm at the next clock edge, unless R10 blocks it.
- R12: With auto_stop_en = 0, a fault leaves tmr_en and pwm_en unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_pins | input | NUM_PINS | Asynchronous fault input pins |
| pin_sel | input | SEL_W | Index of the pin watched by this channel |
| edge_rising | input | 1 | 1: rising edge is a fault, 0: falling edge is a fault |
| filt_en | input | 1 | Glitch filter enable |
| filt_len | input | LEN_W | Filter length; window is 16 x (filt_len + 1) cycles |
| auto_stop_en | input | 1 | Allow a fault to stop the channel's timer and PWM |
| irq_en | input | 1 | Interrupt gate |
| fault_clr | input | 1 | Write-one-to-clear strobe for the pending flag |
| en_wr | input | 1 | Strobe loading the two enable bits |
| en_wr_tmr | input | 1 | Value written to tmr_en |
| en_wr_pwm | input | 1 | Value written to pwm_en |
| fault_pend | output | 1 | Latched fault pending flag |
| fault_irq | output | 1 | Interrupt request |
| tmr_en | output | 1 | Channel timer enable |
| pwm_en | output | 1 | Channel PWM output enable |

## Verification
Two pairs of functions can fall in the same cycle. The first is a release strobe arriving on the edge that registers a new fault. The second is an enable write arriving while the automatic stop is holding the channel. The bench provokes the first pair by re-arming the selected pin while the flag is still set. It then counts the synchronizer stages so that fault_clr is high exactly on the clock edge where the edge detector fires. The flag must still be set afterwards. For the second pair it issues an enable write while the fault is pending with automatic stop on, and both enables must read back 0. A behavioural model, compared on every clock, judges both pairs, together with named checks at the exact cycles.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

  // Active transition chosen for a channel.
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } fault_edge_e;

  // Enable pair owned by the channel.
  typedef struct packed {
    logic tmr;
    logic pwm;
  } run_en_t;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/pwm_fault_sync.sv
module pwm_fault_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;

    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= din[i];
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din[i]};
      end
    end

    assign dout[i] = chain[LAST];
  end

endmodule

// File: rtl/pwm_fault_filter.sv
module pwm_fault_filter #(
  parameter int unsigned LEN_W = 6,
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             en,
  input  logic [LEN_W-1:0] len,
  output logic             level
);

  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic             filt_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [LEN_W-1:0] unit_cnt;
  logic             pre_wrap;
  logic             window_done;

  assign pre_wrap    = (pre_cnt == PRE_LAST);
  assign window_done = pre_wrap && (unit_cnt == len);

  // Prescaler ticks every 2**PRE_W cycles; unit counter counts ticks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q   <= 1'b0;
      pre_cnt  <= '0;
      unit_cnt <= '0;
    end else if (!en) begin
      filt_q   <= din;
      pre_cnt  <= '0;
      unit_cnt <= '0;
    end else if (din == filt_q) begin
      pre_cnt  <= '0;
      unit_cnt <= '0;
    end else if (window_done) begin
      filt_q   <= din;
      pre_cnt  <= '0;
      unit_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt  <= '0;
      unit_cnt <= unit_cnt + 1'b1;
    end else begin
      pre_cnt  <= pre_cnt + 1'b1;
    end
  end

  assign level = en ? filt_q : din;

endmodule

// File: rtl/pwm_fault_edge.sv
module pwm_fault_edge
  import pwm_fault_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic rising,
  output logic hit
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  always_comb begin
    if (fault_edge_e'(rising) == EDGE_RISE) hit = level & ~prev_q;
    else                                     hit = ~level & prev_q;
  end

endmodule

// File: rtl/pwm_fault_latch.sv
module pwm_fault_latch
  import pwm_fault_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic auto_en,
  input  logic irq_en,
  input  logic en_wr,
  input  logic en_wr_tmr,
  input  logic en_wr_pwm,
  output logic pend,
  output logic irq,
  output logic tmr_en,
  output logic pwm_en
);

  logic    pend_q;
  run_en_t run_q;
  logic    halt;

  // A fresh edge outranks the clear strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (hit) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end

  assign halt = auto_en & (hit | pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (halt) begin
      run_q <= '0;
    end else if (en_wr) begin
      run_q.tmr <= en_wr_tmr;
      run_q.pwm <= en_wr_pwm;
    end
  end

  assign pend   = pend_q;
  assign irq    = pend_q & irq_en;
  assign tmr_en = run_q.tmr;
  assign pwm_en = run_q.pwm;

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pwm_fault_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned LEN_W    = 6,
  parameter int unsigned PRE_W    = 4,
  localparam int unsigned SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] fault_pins,
  input  logic [SEL_W-1:0]    pin_sel,
  input  logic                edge_rising,
  input  logic                filt_en,
  input  logic [LEN_W-1:0]    filt_len,
  input  logic                auto_stop_en,
  input  logic                irq_en,
  input  logic                fault_clr,
  input  logic                en_wr,
  input  logic                en_wr_tmr,
  input  logic                en_wr_pwm,
  output logic                fault_pend,
  output logic                fault_irq,
  output logic                tmr_en,
  output logic                pwm_en
);

  logic [NUM_PINS-1:0] pins_sync;
  logic                sel_level;
  logic                filt_level;
  logic                edge_hit;

  pwm_fault_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (fault_pins),
    .dout  (pins_sync)
  );

  assign sel_level = pins_sync[pin_sel];

  pwm_fault_filter #(
    .LEN_W (LEN_W),
    .PRE_W (PRE_W)
  ) u_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (sel_level),
    .en    (filt_en),
    .len   (filt_len),
    .level (filt_level)
  );

  pwm_fault_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (filt_level),
    .rising (edge_rising),
    .hit    (edge_hit)
  );

  pwm_fault_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (edge_hit),
    .clr       (fault_clr),
    .auto_en   (auto_stop_en),
    .irq_en    (irq_en),
    .en_wr     (en_wr),
    .en_wr_tmr (en_wr_tmr),
    .en_wr_pwm (en_wr_pwm),
    .pend      (fault_pend),
    .irq       (fault_irq),
    .tmr_en    (tmr_en),
    .pwm_en    (pwm_en)
  );

endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic fault_clr,
  input logic auto_stop_en,
  input logic fault_pend,
  input logic fault_irq,
  input logic tmr_en,
  input logic pwm_en,
  input logic edge_hit
);

  p_irq_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> fault_pend);

  p_set_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_pend) |-> $past(edge_hit));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_pend && !fault_clr) |=> fault_pend);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && !edge_hit) |=> !fault_pend);

  p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && edge_hit) |=> fault_pend);

  p_auto_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_pend && auto_stop_en) |=> (!tmr_en && !pwm_en));

endmodule

bind pwm_fault_guard pwm_fault_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fault_clr    (fault_clr),
  .auto_stop_en (auto_stop_en),
  .fault_pend   (fault_pend),
  .fault_irq    (fault_irq),
  .tmr_en       (tmr_en),
  .pwm_en       (pwm_en),
  .edge_hit     (edge_hit)
);

// File: tb/tb_pwm_fault_guard.sv
`timescale 1ns/1ps
module tb_pwm_fault_guard;

  localparam int NP  = 8;
  localparam int SW  = 3;
  localparam int LW  = 6;
  localparam int MAX_CYC = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic [SW-1:0] sel = '0;
  logic          rising = 1'b1;
  logic          fen = 1'b0;
  logic [LW-1:0] flen = '0;
  logic          auto_en = 1'b0;
  logic          irq_en = 1'b0;
  logic          clr = 1'b0;
  logic          en_wr = 1'b0;
  logic          wr_tmr = 1'b0;
  logic          wr_pwm = 1'b0;
  logic          pend, irq, tmr, pwm;

  always #10 clk = ~clk;

  pwm_fault_guard #(.NUM_PINS(NP), .LEN_W(LW), .PRE_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .fault_pins(pins), .pin_sel(sel),
    .edge_rising(rising), .filt_en(fen), .filt_len(flen),
    .auto_stop_en(auto_en), .irq_en(irq_en), .fault_clr(clr),
    .en_wr(en_wr), .en_wr_tmr(wr_tmr), .en_wr_pwm(wr_pwm),
    .fault_pend(pend), .fault_irq(irq), .tmr_en(tmr), .pwm_en(pwm)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string phase    = "R1";
  bit    done     = 1'b0;

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [NP-1:0] mq[$];
  bit m_filt, m_prev, m_pend, m_tmr, m_pwm;
  int m_run;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq = {};
      mq.push_back('0);
      mq.push_back('0);
      m_filt = 0; m_prev = 0; m_pend = 0; m_tmr = 0; m_pwm = 0; m_run = 0;
    end else begin
      bit s2, lvl, hit;
      int win;
      s2  = mq[0][sel];
      lvl = fen ? m_filt : s2;
      hit = rising ? (lvl && !m_prev) : (!lvl && m_prev);
      if (auto_en && (hit || m_pend)) begin
        m_tmr = 0; m_pwm = 0;
      end else if (en_wr) begin
        m_tmr = wr_tmr; m_pwm = wr_pwm;
      end
      if (hit) m_pend = 1;
      else if (clr) m_pend = 0;
      m_prev = lvl;
      win = 16 * (int'(flen) + 1);
      if (!fen) begin
        m_filt = s2; m_run = 0;
      end else if (s2 == m_filt) begin
        m_run = 0;
      end else if (m_run == win - 1) begin
        m_filt = s2; m_run = 0;
      end else begin
        m_run++;
      end
      void'(mq.pop_front());
      mq.push_back(pins);
    end
  end

  // Compare on every clock, midway between edges.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, pend, m_pend, "pend vs model");
      chk(phase, irq,  m_pend & irq_en, "irq vs model");
      chk(phase, tmr,  m_tmr, "tmr_en vs model");
      chk(phase, pwm,  m_pwm, "pwm_en vs model");
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_clr();
    clr = 1'b1; step(1); clr = 1'b0;
  endtask

  task automatic write_en(input logic t, input logic p);
    en_wr = 1'b1; wr_tmr = t; wr_pwm = p; step(1); en_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1", pend, 1'b0, "pend after reset");
    chk("R1", irq,  1'b0, "irq after reset");
    chk("R1", tmr,  1'b0, "tmr_en after reset");
    chk("R1", pwm,  1'b0, "pwm_en after reset");

    // R11 enable writes
    phase = "R11";
    write_en(1'b1, 1'b0);
    chk("R11", tmr, 1'b1, "tmr_en loaded");
    chk("R11", pwm, 1'b0, "pwm_en loaded");
    write_en(1'b1, 1'b1);
    chk("R11", pwm, 1'b1, "pwm_en loaded");

    // R2 unselected pin ignored
    phase = "R2";
    sel = 3'd3; rising = 1'b1; irq_en = 1'b1;
    pins[5] = 1'b1; step(6);
    chk("R2", pend, 1'b0, "edge on unselected pin");
    pins[5] = 1'b0; step(4);

    // R4 latency without filter
    phase = "R4";
    pins[3] = 1'b1; step(2);
    chk("R4", pend, 1'b0, "pend before third edge");
    step(1);
    chk("R4", pend, 1'b1, "pend at third edge");
    chk("R9", irq, 1'b1, "irq with enable");
    chk("R12", tmr, 1'b1, "tmr_en kept without auto stop");
    chk("R12", pwm, 1'b1, "pwm_en kept without auto stop");

    phase = "R9";
    irq_en = 1'b0; #1;
    chk("R9", irq, 1'b0, "irq gated off");
    irq_en = 1'b1; #1;

    // R6 sticky
    phase = "R6";
    pins[3] = 1'b0; step(10);
    chk("R6", pend, 1'b1, "pend holds");

    // R7 clear
    phase = "R7";
    pulse_clr();
    chk("R7", pend, 1'b0, "pend cleared");

    // R3 falling polarity
    phase = "R3";
    rising = 1'b0;
    pins[3] = 1'b1; step(6);
    chk("R3", pend, 1'b0, "rising ignored in falling mode");
    pins[3] = 1'b0; step(3);
    chk("R3", pend, 1'b1, "falling edge detected");
    pulse_clr(); step(2);

    // R8 clear and edge in the same cycle
    phase = "R8";
    rising = 1'b1;
    pins[3] = 1'b1; step(4);
    chk("R8", pend, 1'b1, "armed fault");
    pins[3] = 1'b0; step(4);
    chk("R3", pend, 1'b1, "falling ignored in rising mode");
    pins[3] = 1'b1; step(2);
    clr = 1'b1; step(1); clr = 1'b0;
    chk("R8", pend, 1'b1, "edge beats clear");
    phase = "R7";
    pulse_clr();
    chk("R7", pend, 1'b0, "clear with no edge");

    // R10 automatic stop
    phase = "R10";
    auto_en = 1'b1;
    pins[3] = 1'b0; step(4);
    pins[3] = 1'b1; step(3);
    chk("R10", pend, 1'b1, "fault pending");
    chk("R10", tmr, 1'b0, "tmr_en stopped");
    chk("R10", pwm, 1'b0, "pwm_en stopped");
    write_en(1'b1, 1'b1);
    chk("R10", tmr, 1'b0, "write ignored while pending");
    chk("R10", pwm, 1'b0, "write ignored while pending");
    pulse_clr();
    write_en(1'b1, 1'b1);
    chk("R11", tmr, 1'b1, "restart after clear");
    auto_en = 1'b0;

    // R5 filter window 32 cycles
    phase = "R5";
    fen = 1'b1; flen = 6'd1;
    pins[3] = 1'b0; step(40);
    pins[3] = 1'b1; step(20);
    pins[3] = 1'b0; step(40);
    chk("R5", pend, 1'b0, "short pulse rejected");
    pins[3] = 1'b1; step(34);
    chk("R5", pend, 1'b0, "pend before window");
    step(1);
    chk("R5", pend, 1'b1, "pend after window 32");
    pulse_clr();

    // R5 longest window 1024 cycles
    flen = 6'd63;
    pins[3] = 1'b0; step(1100);
    pins[3] = 1'b1; step(1026);
    chk("R5", pend, 1'b0, "pend before window 1024");
    step(1);
    chk("R5", pend, 1'b1, "pend after window 1024");
    step(3);
    finish_run();
  end

endmodule